// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block is a 2048-word by 9-bit dual-port memory with a doorbell mechanism between its two ports, named left and right. Each port has its own chip select, write enable, output enable, address, write data, read data and busy input. Either port can read or write any word. Read data is registered and appears one clock after the access.

The two highest addresses serve as mailboxes. Address 0x7FE belongs to the left port and address 0x7FF belongs to the right port. When one port writes its partner's mailbox, the partner's interrupt output goes active. When the partner then accesses its own mailbox with chip select and output enable active, the interrupt clears. The 9-bit message stays in the mailbox word as ordinary data.

An external arbiter supplies a busy input for each port. A busy port cannot write, set a flag or clear a flag. The mailbox function can be turned off, either at build time through a parameter or at run time through a static enable input. While it is off, both interrupts stay inactive and the top two words are plain storage.

Top module: `dpm_mailbox_top`

## Requirements
- R1: A port writes `wdata` to word `addr` at the clock edge where its `cs_n` and `we_n` are low and its `busy` is low. A port reads when `cs_n` and `oe_n` are low and `we_n` is high. Read data appears on `rdata` after that edge and holds until the next read. A read returns the word as it stood before any write in the same cycle. If both ports write the same word in one cycle, the left port's data is stored.
- R2: A write attempted while that port's `busy` is high leaves the memory unchanged.
- R3: A right-port write to 0x7FE drives `lft_irq_n` low from the following clock edge.
- R4: A left-port access to 0x7FE with `lft_cs_n` and `lft_oe_n` low drives `lft_irq_n` high from the following edge. The level of `lft_we_n` does not matter. If `lft_we_n` is low, the write to memory also takes place.
- R5: A left-port write to 0x7FF drives `rgt_irq_n` low. A right-port access to 0x7FF with `rgt_cs_n` and `rgt_oe_n` low drives it high again.
- R6: Mailbox words hold and return the written 9-bit message unchanged by any flag activity.
- R7: A set or clear attempted by a port whose `busy` is high leaves the flag unchanged.
- R8: When a set and a clear of the same flag happen in one cycle, the flag ends up set.
- R9: While `mbox_en` is low (or the parameter `MBOX_USE` is 0), both `*_irq_n` outputs are high. A write to 0x7FE or 0x7FF then only stores data.
- R10: After a synchronous active-low reset, both `*_irq_n` outputs are high and both `rdata` buses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mbox_en | input | 1 | Static enable for the mailbox interrupt function |
| lft_cs_n | input | 1 | Left chip select, active low |
| lft_we_n | input | 1 | Left write enable, active low |
| lft_oe_n | input | 1 | Left output enable, active low |
| lft_addr | input | 11 | Left word address |
| lft_wdata | input | 9 | Left write data |
| lft_busy | input | 1 | Left busy from the arbiter; blocks left writes and flag actions |
| lft_rdata | output | 9 | Left registered read data |
| lft_irq_n | output | 1 | Left interrupt, active low |
| rgt_cs_n | input | 1 | Right chip select, active low |
| rgt_we_n | input | 1 | Right write enable, active low |
| rgt_oe_n | input | 1 | Right output enable, active low |
| rgt_addr | input | 11 | Right word address |
| rgt_wdata | input | 9 | Right write data |
| rgt_busy | input | 1 | Right busy from the arbiter; blocks right writes and flag actions |
| rgt_rdata | output | 9 | Right registered read data |
| rgt_irq_n | output | 1 | Right interrupt, active low |

## Verification
Each flag is a single register that drives its interrupt pin directly, so a wrong flag state is visible on `*_irq_n` one clock after the access that caused it. A lost set, a missed clear, a busy port that still acts, or a wrong winner in a simultaneous set and clear all show up on the very next cycle. Damage to memory contents, such as a write that slips through while busy or a mailbox word altered by the flag logic, stays hidden until that word is read back. It then appears on `rdata` one clock after the read. A behavioural model therefore compares both interrupts and both read buses on every cycle.

// File: rtl/dpm_pkg.sv
// Package: shared types for the dual-port mailbox memory.
// Assumes two ports only; the port index picks the mailbox word.
package dpm_pkg;

    // Index of each port; left owns the lower mailbox word.
    typedef enum logic {
        PORT_L = 1'b0,
        PORT_R = 1'b1
    } port_id_e;

    // Decoded per-cycle actions of one port.
    typedef struct packed {
        logic wr_go;     // write accepted into the array
        logic rd_go;     // read accepted, updates read register
        logic peer_set;  // write to partner's mailbox word
        logic own_clr;   // access to own mailbox word
    } port_strobe_t;

endpackage

// File: rtl/dpm_port_decode.sv
// Module: dpm_port_decode
// Turns one port's active-low controls, busy and address into the
// array strobes and the mailbox set/clear strobes.
// Assumes: busy gates writes and all flag actions, but not reads.
module dpm_port_decode
    import dpm_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int OWN_MBOX  = 2046,
    parameter int PEER_MBOX = 2047
) (
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    output port_strobe_t      strobe
);

    localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_MBOX);
    localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_MBOX);

    logic sel, wr, rd_en;

    // Decode strobes for this cycle.
    always_comb begin
        sel   = ~cs_n;
        wr    = ~we_n;
        rd_en = ~oe_n;
        strobe.wr_go    = sel & wr & ~busy;
        strobe.rd_go    = sel & rd_en & ~wr;
        strobe.peer_set = sel & wr & ~busy & (addr == PEER_A);
        strobe.own_clr  = sel & rd_en & ~busy & (addr == OWN_A);
    end

endmodule

// File: rtl/dpm_irq_flag.sv
// Module: dpm_irq_flag
// One mailbox interrupt flag. Set wins over clear in the same cycle;
// a low enable forces the flag clear.
// Assumes set/clear are already qualified by busy.
module dpm_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);

    // Flag register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (!enable) flag_q <= 1'b0;
        else if (set_i)   flag_q <= 1'b1;
        else if (clr_i)   flag_q <= 1'b0;
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && set_i) |=> flag_q);

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && clr_i && !set_i) |=> !flag_q);

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !flag_q);

endmodule

// File: rtl/dpm_array.sv
// Module: dpm_array
// Two-port storage with registered read data.
// Assumes: reads return pre-write contents; on a same-word double
// write the left port is applied last and so wins.
module dpm_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage writes; left after right so left wins a collision.
    always_ff @(posedge clk) begin
        if (r_wr) mem[r_addr] <= r_wdata;
        if (l_wr) mem[l_addr] <= l_wdata;
    end

    // Registered read data per port, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (l_rd) l_rdata <= mem[l_addr];
            if (r_rd) r_rdata <= mem[r_addr];
        end
    end

    // R1
    left_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_wr |=> mem[$past(l_addr)] == $past(l_wdata));

endmodule

// File: rtl/dpm_mailbox_top.sv
// Module: dpm_mailbox_top
// 2K x 9 dual-port memory with a mailbox interrupt per port.
// Right write to the left mailbox word raises lft_irq_n; a left
// read-style access to it clears it; mirrored for the right port.
// Assumes busy inputs come from an external arbiter.
module dpm_mailbox_top
    import dpm_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 9,
    parameter bit MBOX_USE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbox_en,
    input  logic              lft_cs_n,
    input  logic              lft_we_n,
    input  logic              lft_oe_n,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic [DATA_W-1:0] lft_wdata,
    input  logic              lft_busy,
    output logic [DATA_W-1:0] lft_rdata,
    output logic              lft_irq_n,
    input  logic              rgt_cs_n,
    input  logic              rgt_we_n,
    input  logic              rgt_oe_n,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic [DATA_W-1:0] rgt_wdata,
    input  logic              rgt_busy,
    output logic [DATA_W-1:0] rgt_rdata,
    output logic              rgt_irq_n
);

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int NPORT    = 2;
    localparam int LFT_MBOX = DEPTH - 2;
    localparam int RGT_MBOX = DEPTH - 1;

    logic [NPORT-1:0]  cs_n_v, we_n_v, oe_n_v, busy_v, flag_v;
    logic [ADDR_W-1:0] addr_v [NPORT];
    port_strobe_t      st_v   [NPORT];
    logic              flag_en;

    // Gather port controls into indexed vectors.
    always_comb begin
        cs_n_v = {rgt_cs_n, lft_cs_n};
        we_n_v = {rgt_we_n, lft_we_n};
        oe_n_v = {rgt_oe_n, lft_oe_n};
        busy_v = {rgt_busy, lft_busy};
        addr_v[PORT_L] = lft_addr;
        addr_v[PORT_R] = rgt_addr;
    end

    assign flag_en = MBOX_USE ? mbox_en : 1'b0;

    // Per-port decoder and the flag that the port owns.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int OWN  = (p == 0) ? LFT_MBOX : RGT_MBOX;
        localparam int PEER = (p == 0) ? RGT_MBOX : LFT_MBOX;

        dpm_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_MBOX (OWN),
            .PEER_MBOX(PEER)
        ) u_dec (
            .cs_n  (cs_n_v[p]),
            .we_n  (we_n_v[p]),
            .oe_n  (oe_n_v[p]),
            .busy  (busy_v[p]),
            .addr  (addr_v[p]),
            .strobe(st_v[p])
        );

        dpm_irq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .enable(flag_en),
            .set_i (st_v[NPORT-1-p].peer_set),
            .clr_i (st_v[p].own_clr),
            .flag_q(flag_v[p])
        );
    end

    dpm_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_wr   (st_v[PORT_L].wr_go),
        .l_rd   (st_v[PORT_L].rd_go),
        .l_addr (lft_addr),
        .l_wdata(lft_wdata),
        .l_rdata(lft_rdata),
        .r_wr   (st_v[PORT_R].wr_go),
        .r_rd   (st_v[PORT_R].rd_go),
        .r_addr (rgt_addr),
        .r_wdata(rgt_wdata),
        .r_rdata(rgt_rdata)
    );

    assign lft_irq_n = ~flag_v[PORT_L];
    assign rgt_irq_n = ~flag_v[PORT_R];

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (lft_irq_n && rgt_irq_n));

endmodule

// File: tb/dpm_mailbox_top_tb.sv
module dpm_mailbox_top_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mbox_en = 1'b1;
    logic l_cs = 1, l_we = 1, l_oe = 1, l_busy = 0;
    logic r_cs = 1, r_we = 1, r_oe = 1, r_busy = 0;
    logic [10:0] l_addr = 0, r_addr = 0;
    logic [8:0]  l_wd = 0, r_wd = 0;
    logic [8:0]  l_rd, r_rd;
    logic        l_irq_n, r_irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dpm_mailbox_top u_dut (
        .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
        .lft_cs_n(l_cs), .lft_we_n(l_we), .lft_oe_n(l_oe),
        .lft_addr(l_addr), .lft_wdata(l_wd), .lft_busy(l_busy),
        .lft_rdata(l_rd), .lft_irq_n(l_irq_n),
        .rgt_cs_n(r_cs), .rgt_we_n(r_we), .rgt_oe_n(r_oe),
        .rgt_addr(r_addr), .rgt_wdata(r_wd), .rgt_busy(r_busy),
        .rgt_rdata(r_rd), .rgt_irq_n(r_irq_n)
    );

    // Behavioural reference model.
    int  m_mem [int];
    int  e_lrd = 0, e_rrd = 0;
    bit  e_lk = 1, e_rk = 1;
    bit  m_lf = 0, m_rf = 0;

    always @(posedge clk) begin
        bit lset, lclr, rset, rclr;
        if (!rst_n) begin
            e_lrd = 0; e_rrd = 0; e_lk = 1; e_rk = 1; m_lf = 0; m_rf = 0;
        end else begin
            lset = !r_cs && !r_we && !r_busy && r_addr == 11'h7FE;
            lclr = !l_cs && !l_oe && !l_busy && l_addr == 11'h7FE;
            rset = !l_cs && !l_we && !l_busy && l_addr == 11'h7FF;
            rclr = !r_cs && !r_oe && !r_busy && r_addr == 11'h7FF;
            if (!l_cs && !l_oe && l_we) begin
                e_lk = m_mem.exists(int'(l_addr));
                if (e_lk) e_lrd = m_mem[int'(l_addr)];
            end
            if (!r_cs && !r_oe && r_we) begin
                e_rk = m_mem.exists(int'(r_addr));
                if (e_rk) e_rrd = m_mem[int'(r_addr)];
            end
            if (!r_cs && !r_we && !r_busy) m_mem[int'(r_addr)] = int'(r_wd);
            if (!l_cs && !l_we && !l_busy) m_mem[int'(l_addr)] = int'(l_wd);
            m_lf = !mbox_en ? 0 : lset ? 1 : lclr ? 0 : m_lf;
            m_rf = !mbox_en ? 0 : rset ? 1 : rclr ? 0 : m_rf;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one cycle, then compare against the model.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk("R3/R4/R7/R8 lft_irq_n model", int'(l_irq_n), int'(!m_lf));
        chk("R5/R7/R9 rgt_irq_n model", int'(r_irq_n), int'(!m_rf));
        if (e_lk) chk("R1/R2/R6 lft_rdata model", int'(l_rd), e_lrd);
        if (e_rk) chk("R1/R2/R6 rgt_rdata model", int'(r_rd), e_rrd);
    endtask

    task automatic idle();
        l_cs = 1; l_we = 1; l_oe = 1; l_busy = 0;
        r_cs = 1; r_we = 1; r_oe = 1; r_busy = 0;
    endtask

    task automatic lwrite(int a, int d, bit b);
        l_cs = 0; l_we = 0; l_oe = 1; l_addr = 11'(a); l_wd = 9'(d); l_busy = b;
    endtask
    task automatic rwrite(int a, int d, bit b);
        r_cs = 0; r_we = 0; r_oe = 1; r_addr = 11'(a); r_wd = 9'(d); r_busy = b;
    endtask
    task automatic lread(int a, bit b);
        l_cs = 0; l_we = 1; l_oe = 0; l_addr = 11'(a); l_busy = b;
    endtask
    task automatic rread(int a, bit b);
        r_cs = 0; r_we = 1; r_oe = 0; r_addr = 11'(a); r_busy = b;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        // R10 reset state
        chk("R10 lft_irq_n", int'(l_irq_n), 1);
        chk("R10 rgt_irq_n", int'(r_irq_n), 1);
        chk("R10 lft_rdata", int'(l_rd), 0);
        chk("R10 rgt_rdata", int'(r_rd), 0);

        // R1 write left, read right
        lwrite(5, 'h1A5, 0); step(); idle();
        rread(5, 0); step(); idle();
        chk("R1 rgt_rdata", int'(r_rd), 'h1A5);

        // R2 busy write blocked
        rwrite(6, 'h055, 0); step(); idle();
        rwrite(6, 'h0AA, 1); step(); idle();
        lread(6, 0); step(); idle();
        chk("R2 lft_rdata", int'(l_rd), 'h055);

        // R3 set left flag
        rwrite('h7FE, 'h123, 0); step(); idle();
        chk("R3 lft_irq_n", int'(l_irq_n), 0);
        chk("R3 rgt_irq_n", int'(r_irq_n), 1);

        // R4 clear by read; R6 message intact
        lread('h7FE, 0); step(); idle();
        chk("R4 lft_irq_n", int'(l_irq_n), 1);
        chk("R6 lft_rdata", int'(l_rd), 'h123);

        // R4 clear with we_n low (write proceeds)
        rwrite('h7FE, 'h0F0, 0); step(); idle();
        l_cs = 0; l_we = 0; l_oe = 0; l_addr = 11'h7FE; l_wd = 9'h1FF;
        step(); idle();
        chk("R4 lft_irq_n we_n low", int'(l_irq_n), 1);
        rread('h7FE, 0); step(); idle();
        chk("R6 rgt_rdata", int'(r_rd), 'h1FF);

        // R5 right flag set and clear; R7 busy blocks clear
        lwrite('h7FF, 'h0C3, 0); step(); idle();
        chk("R5 rgt_irq_n set", int'(r_irq_n), 0);
        rread('h7FF, 1); step(); idle();
        chk("R7 rgt_irq_n busy clear", int'(r_irq_n), 0);
        rread('h7FF, 0); step(); idle();
        chk("R5 rgt_irq_n clear", int'(r_irq_n), 1);
        chk("R6 rgt_rdata mbox", int'(r_rd), 'h0C3);

        // R7 busy blocks set
        rwrite('h7FE, 'h011, 1); step(); idle();
        chk("R7 lft_irq_n busy set", int'(l_irq_n), 1);

        // R8 set and clear same cycle
        rwrite('h7FE, 'h022, 0); lread('h7FE, 0); step(); idle();
        chk("R8 lft_irq_n", int'(l_irq_n), 0);
        lread('h7FE, 0); step(); idle();

        // R9 disabled: flags idle, mailbox is plain memory
        lwrite('h7FF, 'h033, 0); step(); idle();
        mbox_en = 0; step();
        chk("R9 rgt_irq_n forced", int'(r_irq_n), 1);
        rwrite('h7FE, 'h144, 0); step(); idle();
        chk("R9 lft_irq_n", int'(l_irq_n), 1);
        lread('h7FE, 0); step(); idle();
        chk("R9 lft_rdata", int'(l_rd), 'h144);
        mbox_en = 1; step();

        // R1 same-word collision: left wins; read returns old data
        lwrite(9, 'h101, 0); rwrite(9, 'h0EE, 0); step(); idle();
        lwrite(9, 'h077, 0); rread(9, 0); step(); idle();
        chk("R1 rgt_rdata old data", int'(r_rd), 'h101);
        rread(9, 0); step(); idle();
        chk("R1 rgt_rdata collision", int'(r_rd), 'h077);

        // Sweep of mixed traffic compared by the model each cycle
        for (int i = 0; i < 200; i++) begin
            int a = (i % 4 == 0) ? 'h7FE : (i % 4 == 1) ? 'h7FF : (i * 7) % 32;
            case (i % 5)
                0: lwrite(a, i * 3, i % 3 == 0);
                1: rwrite(a, i * 5, i % 4 == 0);
                2: begin lread(a, i % 2 == 0); rwrite(a ^ 1, i, 0); end
                3: begin rread(a, 0); lwrite(a ^ 1, i * 11, 0); end
                default: begin lread(a, 0); rread(a, 0); end
            endcase
            step(); idle();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule